// File: doc/BRIEF.md
# Raster-Op Word Blit Datapath

This block is the per-word datapath of a one-bit-per-pixel framebuffer blitter. The image memory and host bus sit outside it. A completed read of a source word is presented on the source port and latched into a two-word funnel shifter. A host write to a pixel address arrives together with the word currently held at that destination. The block does not store the host value as written. It combines a source word with the destination word under a 4-bit raster-operation code, merges the result through a per-bit write-enable mask, and presents the word to be stored one clock later.

Software sets the behaviour through six small registers. These hold the write mask, the raster-operation code, the mode and shift amount, the raster-op enable and display enable, the source selection, and a display and address register. That last register also accepts a command that returns every setting to its reset value. There are three modes. Direct access passes host data through unchanged. Vector drawing takes its source from the host data through a selector. Block transfer takes its source from the funnel shifter.

Top module: `rop_blit_word`

## Requirements
- R1: After reset the mode is direct access, the write mask is zero, the raster-op code is 0, raster-op is disabled, source select is 00, `wr_valid` is low, `disp_on` is 0 and `dst_hi` is 0.
- R2: In direct-access mode (mode field 111 or any code other than 010 and 100), `wr_data` equals `host_data` unchanged, whatever the mask and raster-op settings.
- R3: With raster-op enabled, the function applied to source S and destination D is selected by the code. 0 gives zero, 1 gives S&D, 2 gives S&~D, 3 gives S, 4 gives ~S&D, 5 gives D, 6 gives S^D, 7 gives S|D, 8 gives ~(S|D), 9 gives ~(S^D), A gives ~D, B gives S|~D, C gives ~S, D gives ~S|D, E gives ~(S&D) and F gives all ones.
- R4: The raster-op register (select 1) arrives byte-swapped on the bus. The code in use is bus bits 11:8, and bus bits 3:0 have no effect.
- R5: In vector and block-transfer modes, each output bit whose mask bit is 1 takes the raster-op result, and each bit whose mask bit is 0 keeps the destination bit.
- R6: Control register 1 (select 3) bit 4 enables raster-op. When it is clear, the result equals the source.
- R7: In vector mode, source select (select 4, bits 7:6) works as follows. 00 forces all ones, 01 replicates `host_data` bit 0 across the word, and 11 (or 10) uses `host_data` as is.
- R8: Each `src_rd` shifts the held word into the previous slot and stores `src_data` as the current word. The block-transfer source is bits [s+15:s] of {previous, current}. Here s is bits 3:0 of control register 0 (select 2), whose bits 7:5 are the mode: 010 vector, 100 block transfer, 111 direct. Bit 4 is ignored.
- R9: When `src_rd` and `dst_wr` fall in the same cycle, the write uses the shifter contents from before that read, and the read is still loaded.
- R10: A register write in the same cycle as `dst_wr` takes effect only for later writes.
- R11: Writing 0x80 to select 5 returns all settings to their reset values.
- R12: Any other write to select 5 stores bit 0 as the display enable and bits HIW:1 as `dst_hi`. `disp_on` is that bit ANDed with control register 1 bit 0.
- R13: `wr_valid` pulses high for exactly the cycle after each `dst_wr` cycle and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 mask, 1 raster-op, 2 mode/shift, 3 enables, 4 source select, 5 display/address/command |
| reg_wdata | input | DW | Register write data |
| src_rd | input | 1 | A source word read has completed |
| src_data | input | DW | Source word read from image memory |
| dst_wr | input | 1 | Host write to a destination address |
| host_data | input | DW | Data of the host write |
| dst_data | input | DW | Word currently stored at the destination |
| wr_valid | output | 1 | Result word is to be stored |
| wr_data | output | DW | Result word |
| disp_on | output | 1 | Display enabled |
| dst_hi | output | HIW | Upper destination address bits |

## Verification
Two pairs of events can fall in the same cycle. A source read can coincide with a destination write, and a register update can coincide with a destination write. The bench provokes both on purpose. It drives `src_rd` and `dst_wr` together, then a mask write together with `dst_wr`. It judges the outcome against a model in which the write always sees the state from before the cycle, and in which the read or the register update shows up only in the next write. Every other cycle is compared against the same model, so a design that lets either update leak forward gives a wrong word either at once or on the write that follows.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

    // Mode field values (control register 0, bits 7:5)
    localparam logic [2:0] MODE_VEC = 3'b010;
    localparam logic [2:0] MODE_BLT = 3'b100;
    localparam logic [2:0] MODE_NRM = 3'b111;

    // Register selects
    localparam logic [2:0] SEL_MASK = 3'd0;
    localparam logic [2:0] SEL_ROP  = 3'd1;
    localparam logic [2:0] SEL_CTL0 = 3'd2;
    localparam logic [2:0] SEL_CTL1 = 3'd3;
    localparam logic [2:0] SEL_CTL2 = 3'd4;
    localparam logic [2:0] SEL_CTL3 = 3'd5;

    // Source select codes
    localparam logic [1:0] SRC_ONES = 2'b00;
    localparam logic [1:0] SRC_REPL = 2'b01;

    localparam logic [7:0] CTL3_RESET_CMD = 8'h80;

    typedef enum logic [1:0] {
        PATH_HOST,
        PATH_VEC,
        PATH_BLT
    } src_path_e;

    // The four code bits are the truth table, indexed by {~s, ~d}
    function automatic logic rop_bit(input logic [3:0] code, input logic s, input logic d);
        logic [1:0] idx;
        idx = {~s, ~d};
        return code[idx];
    endfunction

endpackage

// File: rtl/rbw_regs.sv
module rbw_regs
    import rbw_pkg::*;
#(
    parameter int DW  = 16,
    parameter int SHW = 4,
    parameter int HIW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   cfg_mask,
    output logic [3:0]      cfg_rop,
    output logic [2:0]      cfg_mode,
    output logic [SHW-1:0]  cfg_shift,
    output logic            cfg_rop_en,
    output logic [1:0]      cfg_src_sel,
    output logic            disp_on,
    output logic [HIW-1:0]  dst_hi
);

    typedef struct packed {
        logic [DW-1:0]  mask;
        logic [3:0]     rop;
        logic [2:0]     mode;
        logic [SHW-1:0] shift;
        logic           rop_en;
        logic           disp_gate;
        logic [1:0]     src_sel;
        logic           disp;
        logic [HIW-1:0] hi;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        mask:      '0,
        rop:       4'h0,
        mode:      MODE_NRM,
        shift:     '0,
        rop_en:    1'b0,
        disp_gate: 1'b0,
        src_sel:   2'b00,
        disp:      1'b0,
        hi:        '0
    };

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (reg_sel)
                SEL_MASK: cfg_d.mask = reg_wdata;
                // byte-swapped on the bus: stored low nibble is bus bits 11:8
                SEL_ROP:  cfg_d.rop = reg_wdata[11:8];
                SEL_CTL0: begin
                    cfg_d.mode  = reg_wdata[7:5];
                    cfg_d.shift = reg_wdata[SHW-1:0];
                end
                SEL_CTL1: begin
                    cfg_d.rop_en    = reg_wdata[4];
                    cfg_d.disp_gate = reg_wdata[0];
                end
                SEL_CTL2: cfg_d.src_sel = reg_wdata[7:6];
                SEL_CTL3: begin
                    if (reg_wdata[7:0] == CTL3_RESET_CMD) begin
                        cfg_d = CFG_RST;
                    end else begin
                        cfg_d.disp = reg_wdata[0];
                        cfg_d.hi   = reg_wdata[HIW:1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign cfg_mask    = cfg_q.mask;
    assign cfg_rop     = cfg_q.rop;
    assign cfg_mode    = cfg_q.mode;
    assign cfg_shift   = cfg_q.shift;
    assign cfg_rop_en  = cfg_q.rop_en;
    assign cfg_src_sel = cfg_q.src_sel;
    assign disp_on     = cfg_q.disp & cfg_q.disp_gate;
    assign dst_hi      = cfg_q.hi;

endmodule

// File: rtl/rbw_shift.sv
module rbw_shift #(
    parameter int DW  = 16,
    parameter int SHW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_rd,
    input  logic [DW-1:0]   src_data,
    input  logic [SHW-1:0]  shift,
    output logic [DW-1:0]   shifted
);

    localparam int CW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] prev;
        logic [DW-1:0] cur;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (src_rd) begin
            pipe_d.prev = pipe_q.cur;
            pipe_d.cur  = src_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // Logarithmic funnel: stage k moves the window by 2**k when shift[k] is set
    logic [CW-1:0] stage [SHW+1];
    assign stage[0] = {pipe_q.prev, pipe_q.cur};

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        assign stage[k+1] = shift[k] ? (stage[k] >> (1 << k)) : stage[k];
    end

    assign shifted = stage[SHW][DW-1:0];

endmodule

// File: rtl/rbw_merge.sv
module rbw_merge
    import rbw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [2:0]    mode,
    input  logic [1:0]    src_sel,
    input  logic          rop_en,
    input  logic [3:0]    rop_code,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] host_data,
    input  logic [DW-1:0] shifted,
    input  logic [DW-1:0] dst_data,
    output logic [DW-1:0] result
);

    src_path_e     path;
    logic [DW-1:0] src_vec;
    logic [DW-1:0] src_word;
    logic [DW-1:0] rop_word;
    logic [DW-1:0] func_word;

    always_comb begin
        case (mode)
            MODE_BLT: path = PATH_BLT;
            MODE_VEC: path = PATH_VEC;
            default:  path = PATH_HOST;
        endcase
    end

    always_comb begin
        case (src_sel)
            SRC_ONES: src_vec = '1;
            SRC_REPL: src_vec = {DW{host_data[0]}};
            default:  src_vec = host_data;
        endcase
    end

    always_comb begin
        case (path)
            PATH_BLT: src_word = shifted;
            PATH_VEC: src_word = src_vec;
            default:  src_word = host_data;
        endcase
    end

    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign rop_word[b] = rop_bit(rop_code, src_word[b], dst_data[b]);
    end

    assign func_word = rop_en ? rop_word : src_word;

    always_comb begin
        if (path == PATH_HOST) result = host_data;
        else                   result = (func_word & mask) | (dst_data & ~mask);
    end

endmodule

// File: rtl/rop_blit_word.sv
module rop_blit_word
    import rbw_pkg::*;
#(
    parameter int DW  = 16,
    parameter int HIW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            src_rd,
    input  logic [DW-1:0]   src_data,
    input  logic            dst_wr,
    input  logic [DW-1:0]   host_data,
    input  logic [DW-1:0]   dst_data,
    output logic            wr_valid,
    output logic [DW-1:0]   wr_data,
    output logic            disp_on,
    output logic [HIW-1:0]  dst_hi
);

    localparam int SHW = $clog2(DW);

    logic [DW-1:0]  cfg_mask;
    logic [3:0]     cfg_rop;
    logic [2:0]     cfg_mode;
    logic [SHW-1:0] cfg_shift;
    logic           cfg_rop_en;
    logic [1:0]     cfg_src_sel;
    logic [DW-1:0]  shifted;
    logic [DW-1:0]  merged;

    rbw_regs #(.DW(DW), .SHW(SHW), .HIW(HIW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .cfg_mask    (cfg_mask),
        .cfg_rop     (cfg_rop),
        .cfg_mode    (cfg_mode),
        .cfg_shift   (cfg_shift),
        .cfg_rop_en  (cfg_rop_en),
        .cfg_src_sel (cfg_src_sel),
        .disp_on     (disp_on),
        .dst_hi      (dst_hi)
    );

    rbw_shift #(.DW(DW), .SHW(SHW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_rd   (src_rd),
        .src_data (src_data),
        .shift    (cfg_shift),
        .shifted  (shifted)
    );

    rbw_merge #(.DW(DW)) u_merge (
        .mode      (cfg_mode),
        .src_sel   (cfg_src_sel),
        .rop_en    (cfg_rop_en),
        .rop_code  (cfg_rop),
        .mask      (cfg_mask),
        .host_data (host_data),
        .shifted   (shifted),
        .dst_data  (dst_data),
        .result    (merged)
    );

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.valid = dst_wr;
        out_d.data  = dst_wr ? merged : out_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign wr_valid = out_q.valid;
    assign wr_data  = out_q.data;

endmodule

// File: rtl/rbw_chk.sv
module rbw_chk
    import rbw_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_sel,
    input logic [DW-1:0] reg_wdata,
    input logic          dst_wr,
    input logic [DW-1:0] host_data,
    input logic [DW-1:0] dst_data,
    input logic          wr_valid,
    input logic [DW-1:0] wr_data,
    input logic [2:0]    cfg_mode,
    input logic [DW-1:0] cfg_mask
);

    // R13
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr |=> wr_valid);

    // R13
    no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_wr |=> !wr_valid);

    // R2
    direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_wr && cfg_mode == MODE_NRM) |=> (wr_data == $past(host_data)));

    // R5
    masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_wr && (cfg_mode == MODE_BLT || cfg_mode == MODE_VEC))
        |=> (((wr_data ^ $past(dst_data)) & ~$past(cfg_mask)) == '0));

    // R11
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CTL3 && reg_wdata[7:0] == CTL3_RESET_CMD)
        |=> (cfg_mask == '0 && cfg_mode == MODE_NRM));

endmodule

bind rop_blit_word rbw_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .dst_wr    (dst_wr),
    .host_data (host_data),
    .dst_data  (dst_data),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .cfg_mode  (cfg_mode),
    .cfg_mask  (cfg_mask)
);

// File: tb/tb_rop_blit_word.sv
`timescale 1ns/1ps
module tb_rop_blit_word;

    localparam int DW  = 16;
    localparam int HIW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          src_rd = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          dst_wr = 1'b0;
    logic [DW-1:0] host_data = '0;
    logic [DW-1:0] dst_data = '0;
    logic          wr_valid;
    logic [DW-1:0] wr_data;
    logic          disp_on;
    logic [HIW-1:0] dst_hi;

    always #2.5 clk = ~clk;

    rop_blit_word #(.DW(DW), .HIW(HIW)) dut (.*);

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural model state
    logic [15:0] m_mask, m_prev, m_cur, e_data;
    logic [3:0]  m_code;
    logic [7:0]  m_c0, m_c1, m_c2, m_c3;
    logic        e_valid;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_rop(input logic [3:0] c, input logic [15:0] s, input logic [15:0] d);
        case (c)
            4'h0: return 16'h0000;
            4'h1: return s & d;
            4'h2: return s & ~d;
            4'h3: return s;
            4'h4: return ~s & d;
            4'h5: return d;
            4'h6: return s ^ d;
            4'h7: return s | d;
            4'h8: return ~(s | d);
            4'h9: return ~(s ^ d);
            4'hA: return ~d;
            4'hB: return s | ~d;
            4'hC: return ~s;
            4'hD: return ~s | d;
            4'hE: return ~(s & d);
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [15:0] ref_result(input logic [15:0] h, input logic [15:0] d);
        logic [15:0] s, r;
        logic [31:0] cat;
        if (m_c0[7:5] == 3'b100) begin
            cat = {m_prev, m_cur} >> m_c0[3:0];
            s = cat[15:0];
        end else if (m_c0[7:5] == 3'b010) begin
            if (m_c2[7:6] == 2'b00)      s = 16'hFFFF;
            else if (m_c2[7:6] == 2'b01) s = h[0] ? 16'hFFFF : 16'h0000;
            else                         s = h;
        end else begin
            return h;
        end
        r = m_c1[4] ? ref_rop(m_code, s, d) : s;
        return (r & m_mask) | (d & ~m_mask);
    endfunction

    task automatic model_reset();
        m_mask = 0; m_code = 0; m_c0 = 8'hE0; m_c1 = 0; m_c2 = 0; m_c3 = 0;
    endtask

    // cycle-by-cycle comparison and model step
    always @(negedge clk) begin
        if (!rst_n) begin
            model_reset();
            m_prev = 0; m_cur = 0; e_valid = 0; e_data = 0;
        end else begin
            chk(cur_req, "wr_valid", 32'(wr_valid), 32'(e_valid));
            if (e_valid) chk(cur_req, "wr_data", 32'(wr_data), 32'(e_data));
            chk(cur_req, "disp_on", 32'(disp_on), 32'(m_c1[0] & m_c3[0]));
            chk(cur_req, "dst_hi", 32'(dst_hi), 32'(m_c3[2:1]));
            e_valid = dst_wr;
            if (dst_wr) e_data = ref_result(host_data, dst_data);
            if (src_rd) begin
                m_prev = m_cur;
                m_cur  = src_data;
            end
            if (reg_wr) begin
                case (reg_sel)
                    3'd0: m_mask = reg_wdata;
                    3'd1: m_code = reg_wdata[11:8];
                    3'd2: m_c0 = reg_wdata[7:0];
                    3'd3: m_c1 = reg_wdata[7:0];
                    3'd4: m_c2 = reg_wdata[7:0];
                    3'd5: if (reg_wdata[7:0] == 8'h80) begin model_reset(); m_c3 = 8'h80; end
                          else m_c3 = reg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic reg_w(input logic [2:0] sel, input logic [15:0] data);
        @(posedge clk); #1;
        reg_wr = 1; reg_sel = sel; reg_wdata = data;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic src_load(input logic [15:0] w);
        @(posedge clk); #1;
        src_rd = 1; src_data = w;
        @(posedge clk); #1;
        src_rd = 0;
    endtask

    task automatic do_write(input logic [15:0] h, input logic [15:0] d, input logic [15:0] exp, input string req);
        @(posedge clk); #1;
        dst_wr = 1; host_data = h; dst_data = d;
        @(posedge clk); #1;
        dst_wr = 0;
        @(negedge clk);
        chk(req, "write valid", 32'(wr_valid), 32'd1);
        chk(req, "write data", 32'(wr_data), 32'(exp));
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "wr_valid", 32'(wr_valid), 0);
        chk("R1", "disp_on", 32'(disp_on), 0);
        chk("R1", "dst_hi", 32'(dst_hi), 0);

        cur_req = "R2";
        do_write(16'h1234, 16'hFFFF, 16'h1234, "R2");
        @(negedge clk);
        chk("R13", "single pulse", 32'(wr_valid), 0);
        reg_w(0, 16'hFFFF);
        reg_w(1, 16'h0000);
        reg_w(3, 16'h0010);
        do_write(16'h5A5A, 16'h0F0F, 16'h5A5A, "R2");

        cur_req = "R3";
        reg_w(2, 16'h0040);
        reg_w(4, 16'h00C0);
        for (int c = 0; c < 16; c++) begin
            reg_w(1, 16'(c << 8));
            do_write(16'hA5C3, 16'h0F3C, ref_rop(4'(c), 16'hA5C3, 16'h0F3C), "R3");
        end

        cur_req = "R4";
        reg_w(1, 16'h0006);
        do_write(16'hA5C3, 16'h0F3C, 16'h0000, "R4");
        reg_w(1, 16'h0600);
        do_write(16'hA5C3, 16'h0F3C, 16'hAAFF, "R4");

        cur_req = "R5";
        reg_w(1, 16'h0300);
        reg_w(0, 16'h00FF);
        do_write(16'h1234, 16'hABCD, 16'hAB34, "R5");

        cur_req = "R6";
        reg_w(0, 16'hFFFF);
        reg_w(1, 16'h0000);
        reg_w(3, 16'h0000);
        do_write(16'h1234, 16'hABCD, 16'h1234, "R6");

        cur_req = "R7";
        reg_w(4, 16'h0000);
        do_write(16'h1234, 16'h0000, 16'hFFFF, "R7");
        reg_w(4, 16'h0040);
        do_write(16'h0001, 16'h0000, 16'hFFFF, "R7");
        do_write(16'hFFFE, 16'h0000, 16'h0000, "R7");

        cur_req = "R8";
        reg_w(4, 16'h00C0);
        reg_w(2, 16'h0080);
        src_load(16'h1234);
        src_load(16'hABCD);
        do_write(16'h0000, 16'h0000, 16'hABCD, "R8");
        reg_w(2, 16'h0084);
        do_write(16'h0000, 16'h0000, 16'h4ABC, "R8");
        reg_w(2, 16'h0094);
        do_write(16'h0000, 16'h0000, 16'h4ABC, "R8");
        reg_w(2, 16'h008F);
        do_write(16'h0000, 16'h0000, 16'h2469, "R8");
        reg_w(2, 16'h0084);

        cur_req = "R9";
        @(posedge clk); #1;
        src_rd = 1; src_data = 16'h5678;
        dst_wr = 1; host_data = 0; dst_data = 0;
        @(posedge clk); #1;
        src_rd = 0; dst_wr = 0;
        @(negedge clk);
        chk("R9", "write before load", 32'(wr_data), 32'h4ABC);
        do_write(16'h0000, 16'h0000, 16'hD567, "R9");

        cur_req = "R10";
        @(posedge clk); #1;
        reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0000;
        dst_wr = 1; host_data = 0; dst_data = 16'hFFFF;
        @(posedge clk); #1;
        reg_wr = 0; dst_wr = 0;
        @(negedge clk);
        chk("R10", "old mask used", 32'(wr_data), 32'hD567);
        do_write(16'h0000, 16'h1357, 16'h1357, "R10");

        cur_req = "R11";
        reg_w(0, 16'hFFFF);
        reg_w(3, 16'h0011);
        reg_w(5, 16'h0080);
        do_write(16'h2222, 16'h9999, 16'h2222, "R11");
        reg_w(2, 16'h0040);
        do_write(16'h2222, 16'h9999, 16'h9999, "R11");

        cur_req = "R12";
        reg_w(3, 16'h0001);
        reg_w(5, 16'h0005);
        @(negedge clk);
        chk("R12", "disp_on", 32'(disp_on), 1);
        chk("R12", "dst_hi", 32'(dst_hi), 2);
        reg_w(5, 16'h0006);
        @(negedge clk);
        chk("R12", "disp_on", 32'(disp_on), 0);
        chk("R12", "dst_hi", 32'(dst_hi), 3);
        reg_w(3, 16'h0000);
        reg_w(5, 16'h0001);
        @(negedge clk);
        chk("R12", "gated disp_on", 32'(disp_on), 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule